// File: doc/BRIEF.md
# CAN Fault Confinement Counters

This block keeps the fault confinement bookkeeping of a CAN node. It holds a transmit error counter and a receive error counter. Single-cycle strobes from the bit stream processor move each counter up by one, up by eight, or down by one. From the two counter values the block derives the node condition: error-active, error-passive or bus-off. A dedicated flag reports error-passive and another reports bus-off.

Once the transmit counter reaches the bus-off threshold, the node freezes. Every count strobe is then ignored until the recovery input is raised. Recovery clears both counters and returns the node to error-active. Which protocol events produce which strobes is decided outside this block.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters read 0 and both `err_passive_o` and `bus_off_o` are low.
- R2: An inc1 strobe adds 1 and an inc8 strobe adds 8 to its counter. When several strobes hit one counter in the same cycle, only one is applied: inc8 over inc1, and inc1 over dec.
- R3: The transmit counter never exceeds 256; an increment that would pass 256 leaves it at 256. The receive counter saturates at 255.
- R4: A dec strobe subtracts 1; a counter at 0 stays at 0.
- R5: A dec strobe on the receive counter while it is above 127 loads 127 instead of subtracting 1.
- R6: `err_passive_o` is high exactly when either counter is at least 128 and the transmit counter is below 256.
- R7: `bus_off_o` is high exactly when the transmit counter equals 256, and `err_passive_o` is then low.
- R8: While `bus_off_o` is high, all count strobes are ignored and both counters hold their values.
- R9: `recover_i` during bus-off clears both counters in the next cycle and returns the node to error-active. `recover_i` outside bus-off has no effect.
- R10: Strobes on one counter never change the other counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tec_inc1_i | input | 1 | Add 1 to the transmit counter |
| tec_inc8_i | input | 1 | Add 8 to the transmit counter |
| tec_dec_i | input | 1 | Subtract 1 from the transmit counter |
| rec_inc1_i | input | 1 | Add 1 to the receive counter |
| rec_inc8_i | input | 1 | Add 8 to the receive counter |
| rec_dec_i | input | 1 | Subtract 1 from the receive counter (reload rule above 127) |
| recover_i | input | 1 | Bus-off recovery indication |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 8 | Receive error counter |
| err_passive_o | output | 1 | Node is error-passive |
| bus_off_o | output | 1 | Node is bus-off |

## Verification
A strobe or recovery sampled at one rising edge shows on `tec_o` and `rec_o` right after that edge, so the counter outputs have one cycle of latency. The two flags are decoded from the counter registers without further storage, so they change in that same cycle. The bench drives inputs on the falling edge and lets one rising edge pass. It compares every output at the next falling edge against a model advanced by exactly one step per cycle, so a result that came a cycle early or late would not match.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;

endpackage

// File: rtl/can_fc_cnt.sv
module can_fc_cnt #(
  parameter int          W          = 8,
  parameter int          MAX        = 255,
  parameter bit          RELOAD_EN  = 1'b0,
  parameter int          RELOAD_TH  = 127,
  parameter int          RELOAD_VAL = 127
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         hold_i,
  input  logic         clr_i,
  input  logic         inc1_i,
  input  logic         inc8_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o
);

  localparam logic [W:0]   MAX_W   = (W+1)'(MAX);
  localparam logic [W:0]   STEP1   = (W+1)'(1);
  localparam logic [W:0]   STEP8   = (W+1)'(8);
  localparam logic [W-1:0] TH_V    = W'(RELOAD_TH);
  localparam logic [W-1:0] RELOAD  = W'(RELOAD_VAL);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum1, sum8;
  logic [W-1:0] dec_val;

  assign sum1 = {1'b0, cnt_q} + STEP1;
  assign sum8 = {1'b0, cnt_q} + STEP8;

  generate
    if (RELOAD_EN) begin : g_reload
      assign dec_val = (cnt_q > TH_V) ? RELOAD :
                       (cnt_q == '0)  ? '0 : cnt_q - W'(1);
    end else begin : g_plain
      assign dec_val = (cnt_q == '0) ? '0 : cnt_q - W'(1);
    end
  endgenerate

  // priority: clear, hold, inc8, inc1, dec
  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (hold_i) cnt_d = cnt_q;
    else if (inc8_i) cnt_d = (sum8 > MAX_W) ? MAX_W[W-1:0] : sum8[W-1:0];
    else if (inc1_i) cnt_d = (sum1 > MAX_W) ? MAX_W[W-1:0] : sum1[W-1:0];
    else if (dec_i)  cnt_d = dec_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R4
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !hold_i && !inc1_i && !inc8_i && dec_i && cnt_o == '0) |=> (cnt_o == '0));

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !clr_i) |=> $stable(cnt_o));

  // R9
  clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));

  // R2
  inc1_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !hold_i && !inc8_i && inc1_i && ({1'b0, cnt_o} < MAX_W))
    |=> ({1'b0, cnt_o} == {1'b0, $past(cnt_o)} + STEP1));

  // R3
  ceiling_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, cnt_o} <= MAX_W));

  generate
    if (RELOAD_EN) begin : g_reload_chk
      // R5
      reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_i && !hold_i && !inc1_i && !inc8_i && dec_i && cnt_o > TH_V)
        |=> (cnt_o == RELOAD));
    end
  endgenerate

endmodule

// File: rtl/can_fc_state.sv
module can_fc_state
  import can_fc_pkg::*;
#(
  parameter int TEC_W       = 9,
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TEC_W-1:0] tec_i,
  input  logic [REC_W-1:0] rec_i,
  output fc_state_e        state_o,
  output logic             passive_o,
  output logic             busoff_o
);

  localparam logic [TEC_W-1:0] TEC_PASS = TEC_W'(PASSIVE_LIM);
  localparam logic [TEC_W-1:0] TEC_OFF  = TEC_W'(BUSOFF_LIM);
  localparam logic [REC_W:0]   REC_PASS = (REC_W+1)'(PASSIVE_LIM);

  logic tec_hi, rec_hi, off;

  assign off    = (tec_i >= TEC_OFF);
  assign tec_hi = (tec_i >= TEC_PASS);
  assign rec_hi = ({1'b0, rec_i} >= REC_PASS);

  always_comb begin
    if (off)                   state_o = FC_BUSOFF;
    else if (tec_hi || rec_hi) state_o = FC_PASSIVE;
    else                       state_o = FC_ACTIVE;
  end

  assign passive_o = (state_o == FC_PASSIVE);
  assign busoff_o  = (state_o == FC_BUSOFF);

  // R7
  flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({passive_o, busoff_o}));

  // R6
  active_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tec_hi && !rec_hi) |-> (!passive_o && !busoff_o));

endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int REC_W       = 8,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256,
  parameter int REC_RELOAD  = 127,
  parameter int TEC_W       = $clog2(BUSOFF_LIM + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tec_inc1_i,
  input  logic             tec_inc8_i,
  input  logic             tec_dec_i,
  input  logic             rec_inc1_i,
  input  logic             rec_inc8_i,
  input  logic             rec_dec_i,
  input  logic             recover_i,
  output logic [TEC_W-1:0] tec_o,
  output logic [REC_W-1:0] rec_o,
  output logic             err_passive_o,
  output logic             bus_off_o
);

  localparam int REC_MAX = (1 << REC_W) - 1;

  fc_state_e state;
  logic      busoff, passive, freeze, clear;

  assign freeze = busoff;
  assign clear  = busoff && recover_i;

  can_fc_cnt #(
    .W(TEC_W), .MAX(BUSOFF_LIM), .RELOAD_EN(1'b0),
    .RELOAD_TH(PASSIVE_LIM - 1), .RELOAD_VAL(REC_RELOAD)
  ) u_tec (
    .clk_i, .rst_ni, .hold_i(freeze), .clr_i(clear),
    .inc1_i(tec_inc1_i), .inc8_i(tec_inc8_i), .dec_i(tec_dec_i),
    .cnt_o(tec_o)
  );

  can_fc_cnt #(
    .W(REC_W), .MAX(REC_MAX), .RELOAD_EN(1'b1),
    .RELOAD_TH(PASSIVE_LIM - 1), .RELOAD_VAL(REC_RELOAD)
  ) u_rec (
    .clk_i, .rst_ni, .hold_i(freeze), .clr_i(clear),
    .inc1_i(rec_inc1_i), .inc8_i(rec_inc8_i), .dec_i(rec_dec_i),
    .cnt_o(rec_o)
  );

  can_fc_state #(
    .TEC_W(TEC_W), .REC_W(REC_W),
    .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
  ) u_state (
    .clk_i, .rst_ni, .tec_i(tec_o), .rec_i(rec_o),
    .state_o(state), .passive_o(passive), .busoff_o(busoff)
  );

  assign err_passive_o = passive;
  assign bus_off_o     = busoff;

  // R8
  busoff_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_o && !recover_i) |=> bus_off_o);

  // R9
  recover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_off_o && recover_i) |=> (!bus_off_o && !err_passive_o && tec_o == '0 && rec_o == '0));

  // R10
  rec_indep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rec_inc1_i && !rec_inc8_i && !rec_dec_i && !(bus_off_o && recover_i)) |=> $stable(rec_o));

  // R1
  reset_val_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (state == FC_ACTIVE));

endmodule

// File: tb/can_fault_conf_bench.sv
module can_fault_conf_bench;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tec_inc1 = 0, tec_inc8 = 0, tec_dec = 0;
  logic       rec_inc1 = 0, rec_inc8 = 0, rec_dec = 0, recover = 0;
  logic [8:0] tec;
  logic [7:0] rec;
  logic       passive, busoff;

  int checks = 0, fails = 0;
  int m_tec = 0, m_rec = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_fault_conf u_can_fault_conf (
    .clk_i(clk), .rst_ni(rst_n),
    .tec_inc1_i(tec_inc1), .tec_inc8_i(tec_inc8), .tec_dec_i(tec_dec),
    .rec_inc1_i(rec_inc1), .rec_inc8_i(rec_inc8), .rec_dec_i(rec_dec),
    .recover_i(recover),
    .tec_o(tec), .rec_o(rec), .err_passive_o(passive), .bus_off_o(busoff)
  );

  function automatic int nxt(int cur, bit i1, bit i8, bit d, int mx, bit rl);
    if (i8) return (cur + 8 > mx) ? mx : cur + 8;
    if (i1) return (cur + 1 > mx) ? mx : cur + 1;
    if (d) begin
      if (rl && cur > 127) return 127;
      return (cur > 0) ? cur - 1 : 0;
    end
    return cur;
  endfunction

  function automatic bit exp_off(int t);
    return t >= 256;
  endfunction

  function automatic bit exp_pass(int t, int r);
    return !exp_off(t) && (t >= 128 || r >= 128);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(string t_tec, string t_rec);
    chk(t_tec, int'(tec), m_tec);
    chk(t_rec, int'(rec), m_rec);
    chk("R6 err_passive", int'(passive), int'(exp_pass(m_tec, m_rec)));
    chk("R7 bus_off", int'(busoff), int'(exp_off(m_tec)));
  endtask

  // cmd = {recover, rec_dec, rec_inc8, rec_inc1, tec_dec, tec_inc8, tec_inc1}
  task automatic step(logic [6:0] cmd, string t_tec, string t_rec);
    {recover, rec_dec, rec_inc8, rec_inc1, tec_dec, tec_inc8, tec_inc1} = cmd;
    @(posedge clk);
    if (exp_off(m_tec)) begin
      if (cmd[6]) begin m_tec = 0; m_rec = 0; end
    end else begin
      m_tec = nxt(m_tec, cmd[0], cmd[1], cmd[2], 256, 1'b0);
      m_rec = nxt(m_rec, cmd[3], cmd[4], cmd[5], 255, 1'b1);
    end
    @(negedge clk);
    {recover, rec_dec, rec_inc8, rec_inc1, tec_dec, tec_inc8, tec_inc1} = '0;
    chk_all(t_tec, t_rec);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 tec", int'(tec), 0);
    chk("R1 rec", int'(rec), 0);
    chk("R1 passive", int'(passive), 0);
    chk("R1 bus_off", int'(busoff), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 inc8 beats inc1 beats dec
    step(7'b0000111, "R2 tec prio", "R10 rec");
    chk("R2 tec", int'(tec), 8);
    step(7'b0000101, "R2 tec inc1", "R10 rec");
    chk("R2 tec", int'(tec), 9);
    // R4 dec, floor at zero
    for (int i = 0; i < 10; i++) step(7'b0000100, "R4 tec dec", "R10 rec");
    chk("R4 tec floor", int'(tec), 0);
    step(7'b0100000, "R10 tec", "R4 rec floor");
    chk("R4 rec floor", int'(rec), 0);

    // R6 passive from TEC, R10 rec untouched
    for (int i = 0; i < 16; i++) step(7'b0000010, "R2 tec", "R10 rec");
    chk("R6 passive at 128", int'(passive), 1);
    chk("R10 rec", int'(rec), 0);
    // R9 recover outside bus-off ignored
    step(7'b1000000, "R9 tec", "R9 rec");
    chk("R9 ignored recover", int'(tec), 128);
    // R7 / R3 reach bus-off, clamp
    for (int i = 0; i < 15; i++) step(7'b0000010, "R2 tec", "R10 rec");
    step(7'b0000001, "R3 tec", "R10 rec");
    chk("R3 tec 249", int'(tec), 249);
    step(7'b0000010, "R3 tec clamp", "R10 rec");
    chk("R3 tec clamp", int'(tec), 256);
    chk("R7 bus_off", int'(busoff), 1);
    chk("R7 passive low", int'(passive), 0);
    // R8 all strobes ignored in bus-off
    step(7'b0111111, "R8 tec hold", "R8 rec hold");
    chk("R8 tec hold", int'(tec), 256);
    chk("R8 rec hold", int'(rec), 0);
    // R9 recovery
    step(7'b1000000, "R9 tec clr", "R9 rec clr");
    chk("R9 tec clr", int'(tec), 0);
    chk("R9 bus_off", int'(busoff), 0);

    // R5 rec reload
    for (int i = 0; i < 17; i++) step(7'b0010000, "R10 tec", "R2 rec");
    chk("R6 rec passive", int'(passive), 1);
    step(7'b0100000, "R10 tec", "R5 rec reload");
    chk("R5 rec reload", int'(rec), 127);
    chk("R6 back active", int'(passive), 0);
    // R3 rec saturation
    for (int i = 0; i < 20; i++) step(7'b0010000, "R10 tec", "R3 rec sat");
    chk("R3 rec sat", int'(rec), 255);
    step(7'b0001000, "R10 tec", "R3 rec sat");
    chk("R3 rec sat inc1", int'(rec), 255);
    step(7'b0100000, "R10 tec", "R5 rec reload");
    chk("R5 rec reload from 255", int'(rec), 127);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [6:0] c;
      c[0] = ($urandom % 4) == 0;
      c[1] = ($urandom % 6) == 0;
      c[2] = ($urandom % 3) == 0;
      c[3] = ($urandom % 4) == 0;
      c[4] = ($urandom % 8) == 0;
      c[5] = ($urandom % 3) == 0;
      c[6] = ($urandom % 12) == 0;
      step(c, "R2 tec rand", "R10 rec rand");
    end

    done = 1;
    summary();
    $finish;
  end

endmodule